// File: doc/BRIEF.md
# Command Stream Bus Bridge

This block turns a byte stream of packed command records into single-beat AXI4-Lite transactions. Each record is a sequence of 32-bit words, each sent most-significant byte first. The first word is the target address and the second word holds a command. For a read or a write, a count word follows, and a write then carries its data words. A debug record instead carries a single level word. One packet, which ends on a byte that carries the last marker, may hold any number of records back to back. A read of N words produces a reply of N big-endian words on the outgoing byte stream, and the final reply byte carries the last marker.

Several pieces of logic share the work. A word gatherer assembles incoming bytes into words. A reply serializer sends read data out one byte at a time. A single state machine in the top module sequences parsing and bus traffic. Its states are:

- ST_ADDR: collect the address word.
- ST_CMD: decode the command.
- ST_LEN: take the count word.
- ST_WDATA: collect one write word.
- ST_WREQ: present the write address and data.
- ST_WRSP: wait for the write response.
- ST_RREQ: present the read address.
- ST_RRSP: wait for read data.
- ST_RSEND: wait until the reply word has been sent.
- ST_DBG: take the level word.
- ST_DRAIN: discard the rest of a packet after a bad command.

The transitions are:

- ST_ADDR to ST_CMD.
- ST_CMD to ST_LEN, ST_DBG or ST_DRAIN.
- ST_LEN to ST_WDATA, ST_RREQ or ST_ADDR (when the count is zero).
- ST_WDATA to ST_WREQ, then to ST_WRSP, then back to ST_WDATA or to ST_ADDR.
- ST_RREQ to ST_RRSP, then to ST_RSEND, then back to ST_RREQ or to ST_ADDR.
- ST_DBG to ST_ADDR.
- ST_DRAIN to ST_ADDR on the last byte.
- Any collecting state returns to ST_ADDR when a packet ends early.

Top module: `cab_bridge`

## Requirements
- R1: The first word of a record is the bus address, most-significant byte first. Read and write addresses start there and step by 4 per word.
- R2: The second word's low byte selects the command: 0x00 read, 0x01 write, 0x03 debug. Its upper three bytes have no effect.
- R3: A write record carries a count word, whose low byte is N and whose upper bytes are ignored, followed by N data words. Each data word produces one AXI4-Lite write with all four byte strobes set, to address A+4k.
- R4: A read record with count N performs N reads from A, A+4, and so on. Each read word is emitted as four bytes, most-significant first, and only the final byte of the reply has out_last set.
- R5: A debug record has no count word. The low byte of its third word is loaded into dbg_level.
- R6: Records following one another in a single packet are all executed in order.
- R7: A command byte other than 0x00, 0x01 or 0x03 raises bad_cmd for exactly one cycle. All bytes up to and including the next last-marked byte are then discarded without bus activity. The next packet is parsed normally.
- R8: At most one bus access is in flight at a time. A read never overlaps a write. A valid request keeps its address stable until it is accepted.
- R9: A write or read response other than OKAY (0b00) sets bus_err, which stays set until reset.
- R10: in_ready is low whenever reply bytes are pending on the output.
- R11: A read or write with N = 0 performs no bus access and produces no reply, and parsing continues with the next record.
- R12: A packet that ends in the middle of a record abandons that record after the writes already completed, and the next packet is parsed from its address word.
- R13: After reset, in_ready is high, all valid outputs are low, dbg_level is 0, and bad_cmd and bus_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Command stream byte |
| in_valid | input | 1 | Command byte valid |
| in_last | input | 1 | Byte ends the packet |
| in_ready | output | 1 | Bridge accepts a byte |
| out_data | output | 8 | Reply byte |
| out_valid | output | 1 | Reply byte valid |
| out_last | output | 1 | Final byte of a read reply |
| out_ready | input | 1 | Sink accepts a reply byte |
| m_awaddr | output | 32 | Write address |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address accepted |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write byte strobes |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data accepted |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response accepted |
| m_araddr | output | 32 | Read address |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address accepted |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data accepted |
| dbg_level | output | 8 | Stored debug level |
| bad_cmd | output | 1 | One-cycle pulse on an unknown command |
| bus_err | output | 1 | Sticky bus error |

## Verification
The bench builds the bridge with its default parameters: 32-bit words and an 8-bit count field. With these values a count word's upper bytes can be filled with noise while its low byte stays the real count, and the reply serializer walks all four byte positions of every word. A model bus slave with randomly toggling ready signals and a response-delay path puts address holding and single-outstanding sequencing under stress. An address window that answers with an error code reaches the sticky error path. Random gaps on the input, a random stall on the output sink, and packets cut short mid-word or mid-record reach the discard and restart paths.

// File: rtl/cab_pkg.sv
package cab_pkg;

    typedef enum logic [3:0] {
        ST_ADDR,
        ST_CMD,
        ST_LEN,
        ST_WDATA,
        ST_WREQ,
        ST_WRSP,
        ST_RREQ,
        ST_RRSP,
        ST_RSEND,
        ST_DBG,
        ST_DRAIN
    } cab_state_e;

    localparam logic [7:0] OP_READ  = 8'h00;
    localparam logic [7:0] OP_WRITE = 8'h01;
    localparam logic [7:0] OP_LEVEL = 8'h03;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/cab_word_gather.sv
// Collects big-endian bytes into words; the completed word is presented
// combinationally in the cycle its final byte is accepted.
module cab_word_gather #(
    parameter int BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           byte_i,
    input  logic                 take_i,
    input  logic                 last_i,
    output logic [8*BYTES-1:0]   word_o,
    output logic                 word_vld_o,
    output logic                 word_last_o,
    output logic                 frag_o
);
    localparam int CW = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam int WW = 8 * BYTES;

    logic [WW-1:0] shreg;
    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end      = (cnt == CW'(BYTES - 1));
    assign word_o      = {shreg[WW-9:0], byte_i};
    assign word_vld_o  = take_i && at_end;
    assign word_last_o = take_i && last_i;
    assign frag_o      = take_i && last_i && !at_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (take_i) begin
            shreg <= {shreg[WW-9:0], byte_i};
            if (last_i || at_end) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cab_reply_ser.sv
// Sends a loaded word out as bytes, most significant first.
module cab_reply_ser #(
    parameter int BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [8*BYTES-1:0]   word_i,
    input  logic                 last_i,
    input  logic                 ready_i,
    output logic [7:0]           data_o,
    output logic                 valid_o,
    output logic                 last_o
);
    localparam int CW = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam int WW = 8 * BYTES;

    logic [WW-1:0] shreg;
    logic [CW-1:0] idx;
    logic          vld;
    logic          lastf;

    assign data_o  = shreg[WW-1 -: 8];
    assign valid_o = vld;
    assign last_o  = vld && lastf && (idx == CW'(BYTES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
            vld   <= 1'b0;
            lastf <= 1'b0;
        end else if (load_i) begin
            shreg <= word_i;
            idx   <= '0;
            vld   <= 1'b1;
            lastf <= last_i;
        end else if (vld && ready_i) begin
            shreg <= {shreg[WW-9:0], 8'h00};
            if (idx == CW'(BYTES - 1)) begin
                vld <= 1'b0;
                idx <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cab_bridge.sv
module cab_bridge
    import cab_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int LVL_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           in_data,
    input  logic                 in_valid,
    input  logic                 in_last,
    output logic                 in_ready,
    output logic [7:0]           out_data,
    output logic                 out_valid,
    output logic                 out_last,
    input  logic                 out_ready,
    output logic [DATA_W-1:0]    m_awaddr,
    output logic                 m_awvalid,
    input  logic                 m_awready,
    output logic [DATA_W-1:0]    m_wdata,
    output logic [DATA_W/8-1:0]  m_wstrb,
    output logic                 m_wvalid,
    input  logic                 m_wready,
    input  logic [1:0]           m_bresp,
    input  logic                 m_bvalid,
    output logic                 m_bready,
    output logic [DATA_W-1:0]    m_araddr,
    output logic                 m_arvalid,
    input  logic                 m_arready,
    input  logic [DATA_W-1:0]    m_rdata,
    input  logic [1:0]           m_rresp,
    input  logic                 m_rvalid,
    output logic                 m_rready,
    output logic [LVL_W-1:0]     dbg_level,
    output logic                 bad_cmd,
    output logic                 bus_err
);
    localparam int BYTES = DATA_W / 8;

    cab_state_e st, nxt;

    logic [DATA_W-1:0] word;
    logic              wv, wl, frag, take;
    logic [7:0]        op;
    logic              op_rw;

    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] wdat_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              is_wr_q;
    logic              wlast_q;
    logic              aw_done, w_done;
    logic              aw_hs, w_hs;
    logic [LVL_W-1:0]  lvl_q;
    logic              bad_q, err_q;
    logic              ser_load, ser_busy;

    assign take  = in_valid && in_ready;
    assign op    = word[7:0];
    assign op_rw = (op == OP_READ) || (op == OP_WRITE);
    assign aw_hs = m_awvalid && m_awready;
    assign w_hs  = m_wvalid && m_wready;

    cab_word_gather #(.BYTES(BYTES)) u_gather (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_i      (in_data),
        .take_i      (take),
        .last_i      (in_last),
        .word_o      (word),
        .word_vld_o  (wv),
        .word_last_o (wl),
        .frag_o      (frag)
    );

    assign ser_load = (st == ST_RRSP) && m_rvalid;

    cab_reply_ser #(.BYTES(BYTES)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ser_load),
        .word_i  (m_rdata),
        .last_i  (cnt_q == LEN_W'(1)),
        .ready_i (out_ready),
        .data_o  (out_data),
        .valid_o (ser_busy),
        .last_o  (out_last)
    );

    assign out_valid = ser_busy;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_ADDR;
        end else begin
            st <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_ADDR: begin
                if (wv && !wl) nxt = ST_CMD;
            end
            ST_CMD: begin
                if (wv) begin
                    if (wl)                   nxt = ST_ADDR;
                    else if (op_rw)           nxt = ST_LEN;
                    else if (op == OP_LEVEL)  nxt = ST_DBG;
                    else                      nxt = ST_DRAIN;
                end else if (frag) begin
                    nxt = ST_ADDR;
                end
            end
            ST_LEN: begin
                if (wv) begin
                    if (word[LEN_W-1:0] == '0)  nxt = ST_ADDR;
                    else if (!is_wr_q)         nxt = ST_RREQ;
                    else if (wl)               nxt = ST_ADDR;
                    else                       nxt = ST_WDATA;
                end else if (frag) begin
                    nxt = ST_ADDR;
                end
            end
            ST_WDATA: begin
                if (wv)        nxt = ST_WREQ;
                else if (frag) nxt = ST_ADDR;
            end
            ST_WREQ: begin
                if ((aw_done || aw_hs) && (w_done || w_hs)) nxt = ST_WRSP;
            end
            ST_WRSP: begin
                if (m_bvalid) begin
                    nxt = ((cnt_q == LEN_W'(1)) || wlast_q) ? ST_ADDR : ST_WDATA;
                end
            end
            ST_RREQ: begin
                if (m_arready) nxt = ST_RRSP;
            end
            ST_RRSP: begin
                if (m_rvalid) nxt = ST_RSEND;
            end
            ST_RSEND: begin
                if (!ser_busy) nxt = (cnt_q == '0) ? ST_ADDR : ST_RREQ;
            end
            ST_DBG: begin
                if (wv || frag) nxt = ST_ADDR;
            end
            ST_DRAIN: begin
                if (in_valid && in_last) nxt = ST_ADDR;
            end
            default: nxt = ST_ADDR;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        in_ready  = 1'b0;
        m_awvalid = 1'b0;
        m_wvalid  = 1'b0;
        m_bready  = 1'b0;
        m_arvalid = 1'b0;
        m_rready  = 1'b0;
        unique case (st)
            ST_ADDR, ST_CMD, ST_LEN, ST_WDATA, ST_DBG, ST_DRAIN: in_ready = 1'b1;
            ST_WREQ: begin
                m_awvalid = !aw_done;
                m_wvalid  = !w_done;
            end
            ST_WRSP:  m_bready  = 1'b1;
            ST_RREQ:  m_arvalid = 1'b1;
            ST_RRSP:  m_rready  = 1'b1;
            default: ;
        endcase
    end

    assign m_awaddr  = addr_q;
    assign m_araddr  = addr_q;
    assign m_wdata   = wdat_q;
    assign m_wstrb   = '1;
    assign dbg_level = lvl_q;
    assign bad_cmd   = bad_q;
    assign bus_err   = err_q;

    // Record datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdat_q  <= '0;
            cnt_q   <= '0;
            is_wr_q <= 1'b0;
            wlast_q <= 1'b0;
            aw_done <= 1'b0;
            w_done  <= 1'b0;
            lvl_q   <= '0;
            bad_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            bad_q <= (st == ST_CMD) && wv && !op_rw && (op != OP_LEVEL);
            case (st)
                ST_ADDR: if (wv) addr_q <= word;
                ST_CMD:  if (wv) is_wr_q <= (op == OP_WRITE);
                ST_LEN:  if (wv) cnt_q <= word[LEN_W-1:0];
                ST_WDATA: begin
                    if (wv) begin
                        wdat_q  <= word;
                        wlast_q <= wl;
                    end
                end
                ST_WREQ: begin
                    if (aw_hs) aw_done <= 1'b1;
                    if (w_hs)  w_done  <= 1'b1;
                end
                ST_WRSP: begin
                    if (m_bvalid) begin
                        aw_done <= 1'b0;
                        w_done  <= 1'b0;
                        addr_q  <= addr_q + DATA_W'(BYTES);
                        cnt_q   <= cnt_q - 1'b1;
                        if (m_bresp != RESP_OKAY) err_q <= 1'b1;
                    end
                end
                ST_RRSP: begin
                    if (m_rvalid) begin
                        addr_q <= addr_q + DATA_W'(BYTES);
                        cnt_q  <= cnt_q - 1'b1;
                        if (m_rresp != RESP_OKAY) err_q <= 1'b1;
                    end
                end
                ST_DBG: if (wv) lvl_q <= word[LVL_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cab_bridge_chk.sv
module cab_bridge_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic [7:0]        out_data,
    input logic              out_valid,
    input logic              out_last,
    input logic              out_ready,
    input logic [DATA_W-1:0] m_awaddr,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic              m_wvalid,
    input logic [1:0]        m_bresp,
    input logic              m_bvalid,
    input logic              m_bready,
    input logic [DATA_W-1:0] m_araddr,
    input logic              m_arvalid,
    input logic              m_arready,
    input logic              bad_cmd,
    input logic              bus_err
);
    // R10
    stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R8
    no_mixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid |-> !(m_awvalid || m_wvalid));

    // R8
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    // R8
    ar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

    // R9
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_bvalid && m_bready && (m_bresp != 2'b00)) |=> bus_err);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> bus_err);

    // R7
    bad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |=> !bad_cmd);

    // R4
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind cab_bridge cab_bridge_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_ready (out_ready),
    .m_awaddr  (m_awaddr),
    .m_awvalid (m_awvalid),
    .m_awready (m_awready),
    .m_wvalid  (m_wvalid),
    .m_bresp   (m_bresp),
    .m_bvalid  (m_bvalid),
    .m_bready  (m_bready),
    .m_araddr  (m_araddr),
    .m_arvalid (m_arvalid),
    .m_arready (m_arready),
    .bad_cmd   (bad_cmd),
    .bus_err   (bus_err)
);

// File: tb/tb_cab_bridge.sv
module tb_cab_bridge;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [7:0]  in_data;
    logic        in_valid, in_last, in_ready;
    logic [7:0]  out_data;
    logic        out_valid, out_last;
    logic        out_ready = 1'b0;
    logic [31:0] m_awaddr, m_wdata, m_araddr, m_rdata;
    logic [3:0]  m_wstrb;
    logic        m_awvalid, m_awready, m_wvalid, m_wready;
    logic [1:0]  m_bresp, m_rresp;
    logic        m_bvalid, m_bready, m_arvalid, m_arready, m_rvalid, m_rready;
    logic [7:0]  dbg_level;
    logic        bad_cmd, bus_err;

    cab_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
        .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
        .m_araddr(m_araddr), .m_arvalid(m_arvalid), .m_arready(m_arready),
        .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready),
        .dbg_level(dbg_level), .bad_cmd(bad_cmd), .bus_err(bus_err)
    );

    int errs = 0, checks = 0;
    int bad_seen = 0, overlap = 0, proto_viol = 0, stall_viol = 0;
    logic [7:0]  pkt[$];
    logic [31:0] exp_wa[$], exp_wd[$], got_wa[$], got_wd[$];
    logic [8:0]  exp_rb[$], got_rb[$];
    logic [7:0]  exp_dbg = 8'h00;

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[31:16] + 16'h1234};
    endfunction

    function automatic logic addr_bad(input logic [31:0] a);
        return a[31:28] == 4'hE;
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // Bus slave model with random readiness
    logic        aw_seen, w_seen, r_pend, aw_hold, ar_hold;
    logic [31:0] aw_a, r_a, aw_ha, ar_ha;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_awready <= 0; m_wready <= 0; m_arready <= 0;
            m_bvalid <= 0; m_bresp <= 0; m_rvalid <= 0; m_rresp <= 0; m_rdata <= 0;
            aw_seen <= 0; w_seen <= 0; r_pend <= 0; aw_hold <= 0; ar_hold <= 0;
            aw_a <= 0; r_a <= 0; aw_ha <= 0; ar_ha <= 0;
        end else begin
            m_awready <= 1'($urandom % 2);
            m_wready  <= 1'($urandom % 2);
            m_arready <= 1'($urandom % 2);
            if (m_awvalid && m_awready) begin
                got_wa.push_back(m_awaddr); aw_seen <= 1; aw_a <= m_awaddr;
            end
            if (m_wvalid && m_wready) begin
                got_wd.push_back(m_wdata); w_seen <= 1;
                if (m_wstrb != 4'hF) proto_viol++;
            end
            if (aw_seen && w_seen && !m_bvalid) begin
                m_bvalid <= 1; m_bresp <= addr_bad(aw_a) ? 2'b10 : 2'b00;
            end
            if (m_bvalid && m_bready) begin
                m_bvalid <= 0; aw_seen <= 0; w_seen <= 0;
            end
            if (m_arvalid && m_arready) begin
                r_pend <= 1; r_a <= m_araddr;
            end
            if (r_pend && !m_rvalid) begin
                m_rvalid <= 1; m_rdata <= mem_val(r_a); m_rresp <= addr_bad(r_a) ? 2'b10 : 2'b00;
            end
            if (m_rvalid && m_rready) begin
                m_rvalid <= 0; r_pend <= 0;
            end
            if (m_arvalid && (m_awvalid || m_wvalid || aw_seen || w_seen || m_bvalid)) overlap++;
            if ((m_awvalid || m_wvalid) && (r_pend || m_rvalid)) overlap++;
            if (aw_hold && (!m_awvalid || m_awaddr != aw_ha)) proto_viol++;
            if (ar_hold && (!m_arvalid || m_araddr != ar_ha)) proto_viol++;
            aw_hold <= m_awvalid && !m_awready; aw_ha <= m_awaddr;
            ar_hold <= m_arvalid && !m_arready; ar_ha <= m_araddr;
        end
    end

    // Reply sink and side monitors, away from the active edge
    always @(negedge clk) begin
        out_ready = ($urandom % 4) != 0;
        if (rst_n && out_valid && out_ready) got_rb.push_back({out_last, out_data});
        if (rst_n && out_valid && in_ready) stall_viol++;
        if (rst_n && bad_cmd) bad_seen++;
    end

    task automatic put_word(input logic [31:0] w);
        pkt.push_back(w[31:24]); pkt.push_back(w[23:16]);
        pkt.push_back(w[15:8]);  pkt.push_back(w[7:0]);
    endtask

    task automatic rec_write(input logic [31:0] a, input int n);
        logic [31:0] r1 = $urandom, r2 = $urandom;
        put_word(a);
        put_word({r1[31:8], 8'h01});
        put_word({r2[31:8], 8'(n)});
        for (int k = 0; k < n; k++) begin
            logic [31:0] d = $urandom;
            put_word(d);
            exp_wa.push_back(a + 32'(4 * k));
            exp_wd.push_back(d);
        end
    endtask

    task automatic rec_read(input logic [31:0] a, input int n);
        logic [31:0] r1 = $urandom, r2 = $urandom;
        put_word(a);
        put_word({r1[31:8], 8'h00});
        put_word({r2[31:8], 8'(n)});
        for (int k = 0; k < n; k++) begin
            logic [31:0] v = mem_val(a + 32'(4 * k));
            for (int j = 0; j < 4; j++) begin
                logic lb = (k == n - 1) && (j == 3);
                exp_rb.push_back({lb, v[31 - 8 * j -: 8]});
            end
        end
    endtask

    task automatic rec_dbg(input logic [7:0] lvl);
        logic [31:0] r1 = $urandom, r2 = $urandom, r3 = $urandom;
        put_word(r1);
        put_word({r2[31:8], 8'h03});
        put_word({r3[31:8], lvl});
        exp_dbg = lvl;
    endtask

    task automatic push_byte(input logic [7:0] b, input logic l);
        @(negedge clk);
        in_data = b; in_last = l; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_pkt();
        for (int i = 0; i < pkt.size(); i++) begin
            if ($urandom % 4 == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            push_byte(pkt[i], i == pkt.size() - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        pkt.delete();
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 30) begin
            @(negedge clk);
            if (in_ready && !out_valid && !m_awvalid && !m_wvalid && !m_arvalid &&
                !m_bvalid && !m_rvalid) q++;
            else q = 0;
        end
    endtask

    task automatic compare(input string req);
        check(got_wa.size() == exp_wa.size() && got_wd.size() == exp_wd.size(),
              {req, " write count"}, 64'(got_wa.size()), 64'(exp_wa.size()));
        for (int i = 0; i < exp_wa.size() && i < got_wa.size() && i < got_wd.size(); i++)
            check(got_wa[i] == exp_wa[i] && got_wd[i] == exp_wd[i], {req, " write"},
                  {got_wa[i], got_wd[i]}, {exp_wa[i], exp_wd[i]});
        check(got_rb.size() == exp_rb.size(), {req, " reply length"},
              64'(got_rb.size()), 64'(exp_rb.size()));
        for (int i = 0; i < exp_rb.size() && i < got_rb.size(); i++)
            check(got_rb[i] == exp_rb[i], {req, " reply byte"}, 64'(got_rb[i]), 64'(exp_rb[i]));
        exp_wa.delete(); exp_wd.delete(); got_wa.delete(); got_wd.delete();
        exp_rb.delete(); got_rb.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
        repeat (3) @(negedge clk);
        // R13 reset state
        check(in_ready == 1'b1, "R13 in_ready", 64'(in_ready), 64'd1);
        check(!out_valid && !m_awvalid && !m_wvalid && !m_arvalid, "R13 valids",
              64'({out_valid, m_awvalid, m_wvalid, m_arvalid}), 64'd0);
        check(dbg_level == 8'h00 && !bad_cmd && !bus_err, "R13 level and flags",
              64'({dbg_level, bad_cmd, bus_err}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3: one write record with noisy upper command bytes
        rec_write(32'h0000_0010, 3);
        send_pkt(); wait_quiet(); compare("R1 R2 R3");

        // R4 R10: a read of four words
        rec_read(32'h1234_5670, 4);
        send_pkt(); wait_quiet(); compare("R4 R10");

        // R5: debug record
        rec_dbg(8'h02);
        send_pkt(); wait_quiet();
        check(dbg_level == 8'h02, "R5 level", 64'(dbg_level), 64'h02);

        // R6: several records in one packet
        rec_write(32'h0000_0100, 2);
        rec_read(32'h0000_0200, 2);
        rec_dbg(8'h01);
        rec_read(32'h0000_0300, 1);
        send_pkt(); wait_quiet(); compare("R6 mixed");
        check(dbg_level == 8'h01, "R6 R5 level", 64'(dbg_level), 64'h01);

        // R11: zero-length read, then a write
        rec_read(32'h0000_0400, 0);
        rec_write(32'h0000_0500, 1);
        send_pkt(); wait_quiet(); compare("R11");

        // R7: unknown command discards the rest of the packet
        put_word(32'h0000_0600);
        put_word(32'h0000_0002);
        put_word(32'h0000_0700);
        put_word(32'h0000_0001);
        put_word(32'h0000_0001);
        put_word(32'hDEAD_BEEF);
        send_pkt(); wait_quiet();
        check(bad_seen == 1, "R7 pulse count", 64'(bad_seen), 64'd1);
        compare("R7 discard");
        rec_write(32'h0000_0800, 1);
        send_pkt(); wait_quiet(); compare("R7 next packet");

        // R12: packet cut inside a data word
        put_word(32'h0000_0900);
        put_word(32'h0000_0001);
        put_word(32'h0000_0003);
        put_word(32'hCAFE_0001);
        exp_wa.push_back(32'h0000_0900); exp_wd.push_back(32'hCAFE_0001);
        pkt.push_back(8'h11); pkt.push_back(8'h22);
        send_pkt(); wait_quiet(); compare("R12 truncated");
        rec_read(32'h0000_0A00, 2);
        send_pkt(); wait_quiet(); compare("R12 resume");

        // R9: error response is sticky
        check(bus_err == 1'b0, "R9 clear before", 64'(bus_err), 64'd0);
        rec_read(32'hE000_0010, 1);
        send_pkt(); wait_quiet(); compare("R9 error read");
        check(bus_err == 1'b1, "R9 set", 64'(bus_err), 64'd1);
        rec_write(32'h0000_0B00, 1);
        send_pkt(); wait_quiet(); compare("R9 later write");
        check(bus_err == 1'b1, "R9 sticky", 64'(bus_err), 64'd1);

        // R6: random packets of random records
        for (int p = 0; p < 20; p++) begin
            int nrec = 1 + int'($urandom % 3);
            for (int r = 0; r < nrec; r++) begin
                int sel = int'($urandom % 3);
                logic [31:0] a = $urandom & 32'h7FFF_FFFC;
                if (sel == 0) rec_write(a, int'($urandom % 5));
                else if (sel == 1) rec_read(a, int'($urandom % 5));
                else rec_dbg(8'($urandom % 3));
            end
            send_pkt(); wait_quiet(); compare("R6 random");
        end
        check(dbg_level == exp_dbg, "R5 final level", 64'(dbg_level), 64'(exp_dbg));
        check(overlap == 0, "R8 overlap", 64'(overlap), 64'd0);
        check(proto_viol == 0, "R8 hold and strobes", 64'(proto_viol), 64'd0);
        check(stall_viol == 0, "R10 stall", 64'(stall_viol), 64'd0);
        check(bad_seen == 1, "R7 no spurious pulse", 64'(bad_seen), 64'd1);
        finish_run();
    end

endmodule